// File: doc/BRIEF.md
# Transport Frame Pulse and Payload-Slot Generator

This block runs on the 77.76 MHz system clock and divides time into transport frames of 9720 byte slots, repeating at 8 kHz. Each frame has nine rows. Each row opens with 36 overhead slots and continues with 1044 payload slots. A one-cycle frame pulse marks the first overhead slot of every frame.

A byte-wide user source connects through a ready/valid handshake. Ready is offered only in payload slots. The block merges the user bytes into a byte-wide stream for one transmit channel. Overhead slots and payload slots with no user byte carry a filler byte (0x00) and have the output valid flag low.

A payload slot that the user cannot fill sets a sticky underrun flag. A write-one clear input clears it. The row index and a payload-slot indicator are brought out so that the frame structure can be observed directly.

Top module: `frame_slot_gen`

## Requirements
- R1: `frame_pulse` is high for exactly one cycle every 9720 cycles. The first pulse is in the first cycle after `rst_n` is released.
- R2: Counting slots from a frame pulse, slot k has column k mod 1080 and `row_idx` = (k div 1080) mod 9. `pay_slot` is high exactly when the column is 36 or more.
- R3: `in_ready` is high in every payload slot and low in every overhead slot.
- R4: In a payload slot with `in_valid` high, `out_data` equals `in_data` in the same cycle and `out_valid` is high.
- R5: In an overhead slot, `out_data` is 0x00 and `out_valid` is low, whatever the values of `in_valid` and `in_data`.
- R6: In a payload slot with `in_valid` low, `out_data` is 0x00 and `out_valid` is low. `underrun` is high from the next cycle.
- R7: `underrun` stays high until a cycle with `clr_underrun` high and no new underrun, and reads low from the following cycle. When a clear and a new underrun arrive in the same cycle, the underrun wins. An overhead slot with `in_valid` low never sets the flag.
- R8: While `rst_n` is low at a clock edge, the slot and row counters and `underrun` are cleared. During reset, `frame_pulse`, `in_ready` and `out_valid` are low.
- R9: Every frame holds exactly 9396 cycles with `pay_slot` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 77.76 MHz system clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_data | input | 8 | User byte |
| in_valid | input | 1 | User byte present |
| in_ready | output | 1 | Block accepts a user byte this cycle (payload slot) |
| clr_underrun | input | 1 | Write-one clear of the underrun flag |
| out_data | output | 8 | Merged byte toward the transmit channel |
| out_valid | output | 1 | Output byte is user payload |
| frame_pulse | output | 1 | One-cycle marker of the first slot of a frame |
| row_idx | output | 4 | Current row, 0 to 8 |
| pay_slot | output | 1 | Current slot is a payload slot |
| underrun | output | 1 | Sticky flag: a payload slot went unfilled |

## Verification
The first frame drives `in_valid` high in every payload slot and toggles it in overhead slots. This separates correct overhead masking and filler insertion from a merge that leaks user bytes, and it shows that an idle overhead slot never raises the underrun flag. The second frame uses a gapped valid pattern with scattered clears, some of which land in the same slot as a miss. This distinguishes set-over-clear priority and stickiness from a flag that only pulses or that a clear can override. A reset in the middle of a row, followed by a run across a row boundary, checks that both counters restart together and that the frame pulse returns in the first slot. Per-frame payload and pulse counts catch off-by-one errors in row length or row count.

// File: rtl/fsg_pkg.sv
// Shared types for the frame slot generator.
// Assumes: consumers import the package; no state lives here.
package fsg_pkg;
    typedef enum logic {
        SLOT_OVH = 1'b0,
        SLOT_PAY = 1'b1
    } slot_kind_e;

    // Width able to hold values 0..n-1, never below one bit.
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/fsg_slot_counter.sv
// Column and row counters for the frame grid.
// Does: walks column 0..OVH_SLOTS+PAY_SLOTS-1 and row 0..NUM_ROWS-1 and
//       classifies each slot as overhead or payload.
// Assumes: synchronous active-low reset puts the grid at column 0, row 0.
module fsg_slot_counter
    import fsg_pkg::*;
#(
    parameter int OVH_SLOTS = 36,
    parameter int PAY_SLOTS = 1044,
    parameter int NUM_ROWS  = 9,
    parameter int ROW_W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [ROW_W-1:0] row,
    output slot_kind_e       kind,
    output logic             at_start
);
    localparam int ROW_SLOTS = OVH_SLOTS + PAY_SLOTS;
    localparam int COL_W     = idx_width(ROW_SLOTS);

    logic [COL_W-1:0] col;

    // Advance the column every cycle and step the row on column wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col <= '0;
            row <= '0;
        end else if (col == COL_W'(ROW_SLOTS - 1)) begin
            col <= '0;
            row <= (row == ROW_W'(NUM_ROWS - 1)) ? '0 : row + 1'b1;
        end else begin
            col <= col + 1'b1;
        end
    end

    // Classify the current slot and flag the first slot of the frame.
    always_comb begin
        kind     = (col >= COL_W'(OVH_SLOTS)) ? SLOT_PAY : SLOT_OVH;
        at_start = (col == '0) && (row == '0);
    end
endmodule

// File: rtl/fsg_merge.sv
// Output merge for one transmit byte lane.
// Does: offers ready in payload slots, passes an accepted user byte,
//       and inserts the filler byte everywhere else.
// Assumes: run is low during reset so nothing is accepted then.
module fsg_merge
    import fsg_pkg::*;
#(
    parameter int              DATA_W = 8,
    parameter logic [DATA_W-1:0] FILL = '0
) (
    input  slot_kind_e        kind,
    input  logic              run,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid,
    output logic              miss
);
    // Handshake and byte selection for the current slot.
    always_comb begin
        in_ready  = run && (kind == SLOT_PAY);
        out_valid = in_ready && in_valid;
        out_data  = out_valid ? in_data : FILL;
        miss      = in_ready && !in_valid;
    end
endmodule

// File: rtl/fsg_underrun.sv
// Sticky underrun flag with write-one clear.
// Does: sets on a missed payload slot and clears on request. Set has priority.
// Assumes: miss is already qualified by payload slot and reset.
module fsg_underrun (
    input  logic clk,
    input  logic rst_n,
    input  logic miss,
    input  logic clr,
    output logic flag
);
    // Hold the flag. A new miss outranks a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)    flag <= 1'b0;
        else if (miss) flag <= 1'b1;
        else if (clr)  flag <= 1'b0;
    end
endmodule

// File: rtl/frame_slot_gen.sv
// Transport frame pulse and payload-slot generator (top).
// Does: divides the system clock into frames of NUM_ROWS rows, each row being
//       OVH_SLOTS overhead slots then PAY_SLOTS payload slots, and merges
//       user bytes into the payload slots.
// Assumes: one slot per clock; synchronous active-low reset; outputs are
//          combinational from the slot state and user inputs.
module frame_slot_gen
    import fsg_pkg::*;
#(
    parameter int              OVH_SLOTS = 36,
    parameter int              PAY_SLOTS = 1044,
    parameter int              NUM_ROWS  = 9,
    parameter int              DATA_W    = 8,
    parameter logic [DATA_W-1:0] FILL    = '0,
    parameter int              ROW_W     = idx_width(NUM_ROWS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              clr_underrun,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid,
    output logic              frame_pulse,
    output logic [ROW_W-1:0]  row_idx,
    output logic              pay_slot,
    output logic              underrun
);
    slot_kind_e kind;
    logic       at_start;
    logic       miss;

    fsg_slot_counter #(
        .OVH_SLOTS (OVH_SLOTS),
        .PAY_SLOTS (PAY_SLOTS),
        .NUM_ROWS  (NUM_ROWS),
        .ROW_W     (ROW_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .row      (row_idx),
        .kind     (kind),
        .at_start (at_start)
    );

    fsg_merge #(
        .DATA_W (DATA_W),
        .FILL   (FILL)
    ) u_merge (
        .kind      (kind),
        .run       (rst_n),
        .in_data   (in_data),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .out_data  (out_data),
        .out_valid (out_valid),
        .miss      (miss)
    );

    fsg_underrun u_ur (
        .clk   (clk),
        .rst_n (rst_n),
        .miss  (miss),
        .clr   (clr_underrun),
        .flag  (underrun)
    );

    // Frame marker and slot indicator, held low while in reset.
    always_comb begin
        frame_pulse = at_start && rst_n;
        pay_slot    = (kind == SLOT_PAY);
    end
endmodule

// File: rtl/fsg_checker.sv
// Property checker for frame_slot_gen, attached by bind.
// Does: checks frame period, slot structure, merge rules and the underrun flag.
// Assumes: a frame-length window counter is kept here, not via $past depth.
module fsg_checker #(
    parameter int              OVH_SLOTS = 36,
    parameter int              PAY_SLOTS = 1044,
    parameter int              NUM_ROWS  = 9,
    parameter int              DATA_W    = 8,
    parameter logic [DATA_W-1:0] FILL    = '0,
    parameter int              ROW_W     = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] in_data,
    input logic              in_valid,
    input logic              in_ready,
    input logic              clr_underrun,
    input logic [DATA_W-1:0] out_data,
    input logic              out_valid,
    input logic              frame_pulse,
    input logic [ROW_W-1:0]  row_idx,
    input logic              pay_slot,
    input logic              underrun
);
    localparam int FRAME_LEN = (OVH_SLOTS + PAY_SLOTS) * NUM_ROWS;
    localparam int CW        = $clog2(FRAME_LEN) + 1;

    logic [CW-1:0] since;
    logic          seen;

    // Count cycles since the last frame pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since <= '0;
            seen  <= 1'b0;
        end else if (frame_pulse) begin
            since <= '0;
            seen  <= 1'b1;
        end else begin
            since <= since + 1'b1;
        end
    end

    assert_pulse_period_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_pulse && seen) |-> (since == CW'(FRAME_LEN - 1)));

    assert_no_late_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        seen |-> (since < CW'(FRAME_LEN)));

    assert_pulse_in_overhead_R2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_pulse |-> (!pay_slot && row_idx == '0));

    assert_row_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        row_idx < ROW_W'(NUM_ROWS));

    assert_ready_payload_R3: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready == pay_slot);

    assert_pass_through_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && in_valid) |-> (out_valid && out_data == in_data));

    assert_overhead_filler_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !pay_slot |-> (!out_valid && out_data == FILL));

    assert_underrun_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pay_slot && !in_valid) |=> underrun);

    assert_underrun_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (underrun && !clr_underrun) |=> underrun);

    assert_underrun_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underrun) |-> $past(pay_slot && !in_valid));
endmodule

bind frame_slot_gen fsg_checker #(
    .OVH_SLOTS (OVH_SLOTS),
    .PAY_SLOTS (PAY_SLOTS),
    .NUM_ROWS  (NUM_ROWS),
    .DATA_W    (DATA_W),
    .FILL      (FILL),
    .ROW_W     (ROW_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_data      (in_data),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .clr_underrun (clr_underrun),
    .out_data     (out_data),
    .out_valid    (out_valid),
    .frame_pulse  (frame_pulse),
    .row_idx      (row_idx),
    .pay_slot     (pay_slot),
    .underrun     (underrun)
);

// File: tb/sim_frame_slot_gen.sv
module sim_frame_slot_gen;
    localparam int CLK_PERIOD = 10;
    localparam int OVH   = 36;
    localparam int PAY   = 1044;
    localparam int ROWS  = 9;
    localparam int RLEN  = OVH + PAY;
    localparam int FLEN  = RLEN * ROWS;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_valid = 1'b0;
    logic       clr_underrun = 1'b0;
    logic       in_ready, out_valid, frame_pulse, pay_slot, underrun;
    logic [7:0] out_data;
    logic [3:0] row_idx;

    int checks = 0;
    int errors = 0;
    int k = 0;
    int pay_cnt = 0;
    int pulse_cnt = 0;
    logic exp_ur = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    frame_slot_gen u0 (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
        .in_ready(in_ready), .clr_underrun(clr_underrun), .out_data(out_data),
        .out_valid(out_valid), .frame_pulse(frame_pulse), .row_idx(row_idx),
        .pay_slot(pay_slot), .underrun(underrun)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s slot=%0d actual=%0d expected=%0d", req, what, k, act, exp);
        end
    endtask

    // Reset for n cycles with in_valid high; check the reset state (R8).
    task automatic do_reset(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rst_n = 1'b0; in_valid = 1'b1; in_data = 8'hA5; clr_underrun = 1'b0;
            #1;
            chk(frame_pulse == 1'b0, "R8", "pulse in reset", frame_pulse, 0);
            chk(in_ready == 1'b0, "R8", "ready in reset", in_ready, 0);
            chk(out_valid == 1'b0, "R8", "valid in reset", out_valid, 0);
            if (i > 0) begin
                chk(row_idx == 4'd0, "R8", "row in reset", row_idx, 0);
                chk(underrun == 1'b0, "R8", "underrun in reset", underrun, 0);
            end
        end
        k = 0; pay_cnt = 0; exp_ur = 1'b0;
    endtask

    // One slot: drive at negedge, check mid-cycle, then advance the model.
    task automatic slot(input logic v, input logic [7:0] d, input logic clr);
        int  col, row;
        bit  pay, fp, eov;
        @(negedge clk);
        rst_n = 1'b1; in_valid = v; in_data = d; clr_underrun = clr;
        #1;
        col = k % RLEN;
        row = (k / RLEN) % ROWS;
        pay = (col >= OVH);
        fp  = (k % FLEN == 0);
        eov = pay && v;
        if (fp && k > 0) begin
            chk(pay_cnt == ROWS * PAY, "R9", "payload slots per frame", pay_cnt, ROWS * PAY);
            pay_cnt = 0;
        end
        chk(frame_pulse == fp, "R1", "frame_pulse", frame_pulse, fp);
        chk(row_idx == row[3:0], "R2", "row_idx", row_idx, row);
        chk(pay_slot == pay, "R2", "pay_slot", pay_slot, pay);
        chk(in_ready == pay, "R3", "in_ready", in_ready, pay);
        if (pay && v) begin
            chk(out_valid == 1'b1, "R4", "out_valid", out_valid, 1);
            chk(out_data == d, "R4", "out_data", out_data, d);
        end else if (!pay) begin
            chk(out_valid == 1'b0, "R5", "out_valid", out_valid, 0);
            chk(out_data == 8'h00, "R5", "out_data", out_data, 0);
        end else begin
            chk(out_valid == eov, "R6", "out_valid", out_valid, eov);
            chk(out_data == 8'h00, "R6", "out_data", out_data, 0);
        end
        chk(underrun == exp_ur, "R7", "underrun", underrun, exp_ur);
        if (pay) pay_cnt++;
        if (frame_pulse) pulse_cnt++;
        if (pay && !v)  exp_ur = 1'b1;
        else if (clr)   exp_ur = 1'b0;
        k++;
    endtask

    initial begin
        #(CLK_PERIOD * 60000);
        errors++;
        $display("FAIL watchdog expired at slot %0d", k);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        do_reset(4);
        // Frame A: full payload supply, overhead valid toggling (R4, R5, R7).
        for (int i = 0; i < FLEN; i++) begin
            automatic int c = k % RLEN;
            slot((c < OVH) ? logic'(k[0]) : 1'b1, k[7:0] ^ 8'h5A, 1'b0);
        end
        chk(underrun == 1'b0, "R7", "no underrun after full frame", underrun, 0);
        // Frame B: gapped supply, scattered clears, some with a miss (R6, R7).
        for (int i = 0; i < FLEN; i++) begin
            slot((k % 7) != 3, k[7:0] + 8'h11, (k % 400 == 3) || (k % 400 == 200));
        end
        slot(1'b1, 8'h3C, 1'b1);
        chk(pulse_cnt == 3, "R1", "pulse count over two frames", pulse_cnt, 3);
        // Reset in mid-row, then cross a row boundary (R8, R1, R2).
        for (int i = 0; i < 500; i++) slot(1'b0, 8'hFF, 1'b0);
        do_reset(3);
        for (int i = 0; i < RLEN + 50; i++) slot(1'b1, k[7:0], 1'b0);
        // Miss then clear with no new miss (R6, R7).
        for (int i = 0; i < 3; i++) slot(1'b0, 8'h00, 1'b0);
        slot(1'b1, 8'h77, 1'b1);
        slot(1'b1, 8'h78, 1'b0);
        chk(underrun == 1'b0, "R7", "cleared after write-one", underrun, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule